// File: doc/BRIEF.md
# Secure and Privileged Register Access Filter

This block sits between a simple register bus and a small bank of configuration registers. It decides, for each access in the cycle it is presented, whether the read data may be returned and whether the write may land. The decision uses three inputs: a chip-wide security-enable input, the guard bits of its own security-configuration register, and the secure and privileged attributes that come with the access. A blocked read returns zero and a blocked write leaves the register unchanged. Some blocked accesses are silent. Others raise a one-cycle illegal-access pulse for an interrupt controller outside the block.

The bank holds eight word registers. The security-configuration register is at index 0 and holds the guard bits. The remaining registers are placeholders for settings elsewhere in the chip: the FPU exception-interrupt mask, a nonsecure CPU lock, a secure CPU lock, a safety-lock set, an erase-status word, a compensation control word and a compensation code. Each register's current contents also drive a port, so the rest of the chip can use the settings.

Top module: `regsec_filter`

## Requirements
- R1: After reset, the registers at indices 1 (FPU mask) and 7 (compensation code) read 0x1F and 0x78. All other registers read 0. Bit 5 of the FPU mask is therefore clear.
- R2: While `sec_en_i` is 0, indices 0 (security configuration) and 3 (secure lock) read as zero and ignore writes. No illegal-access pulse is raised.
- R3: While `sec_en_i` is 1, index 0 can be read by any access. A write to it from a nonsecure access is ignored and raises the illegal-access pulse.
- R4: Index 0 keeps only bits 0, 1 and 3. All other bits always read 0.
- R5: With `sec_en_i` at 1, a set guard bit makes its registers secure-only. Bit 0 guards indices 5, 6 and 7, bit 1 guards index 4, and bit 3 guards index 1. A nonsecure read of a guarded register returns 0, a nonsecure write to it is ignored, and both raise the illegal-access pulse. When the guard bit is clear, there is no security restriction.
- R6: Bit 3 of index 0 changes only on a privileged write. An unprivileged write that is otherwise allowed still updates bits 0 and 1.
- R7: Indices 1, 2 and 3 are privileged-only. An unprivileged access to them reads zero or is ignored, and raises no illegal-access pulse when privilege alone blocks it.
- R8: An access blocked by both security and privilege reads zero and raises the illegal-access pulse.
- R9: `illegal_evt_o` is high only in a cycle that carries a valid, nonsecure access while `sec_en_i` is 1. It is low in every idle cycle.
- R10: While `sec_en_i` is 1, index 3 is fully usable by secure privileged accesses. A nonsecure access to it reads zero or is ignored, and raises the illegal-access pulse.
- R11: Read data is returned in the cycle of the access. An accepted write shows on the register outputs after the next rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_en_i | input | 1 | Chip-wide security enable |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Register word index |
| acc_wdata_i | input | DATA_W | Write data |
| acc_secure_i | input | 1 | Access carries the secure attribute |
| acc_priv_i | input | 1 | Access carries the privileged attribute |
| acc_rdata_o | output | DATA_W | Read data, zero when blocked |
| illegal_evt_o | output | 1 | One-cycle illegal-access pulse |
| sec_cfg_o | output | 4 | Security-configuration guard bits |
| fpu_ie_o | output | FPU_W | FPU exception interrupt enables |
| ns_lock_o | output | NSLK_W | Nonsecure CPU lock bits |
| s_lock_o | output | SLK_W | Secure CPU lock bits |
| safe_lock_o | output | SAFE_W | Safety-lock bits |
| erase_o | output | ERASE_W | Erase-status placeholder |
| comp_ctl_o | output | CCTL_W | Compensation control placeholder |
| comp_code_o | output | CCODE_W | Compensation code |

## Verification
The assertions check several properties on every cycle:
- The illegal-access pulse only ever accompanies a valid nonsecure access with security enabled.
- Reads that security-off, privilege or a set system guard should block always return zero.
- The reserved bit of the configuration register stays clear.
- The configuration bits and the FPU mask change only after a write carrying the right attributes.

Other behaviours need the bench's directed scenarios, because they depend on what was written earlier:
- writes dropped while security is off, then read back once it is enabled;
- bit 3 surviving an unprivileged write;
- the write-to-output timing;
- each guard bit protecting exactly its own registers.

// File: rtl/regsec_pkg.sv
package regsec_pkg;

   typedef enum logic [2:0] {
      RID_SCFG  = 3'd0,
      RID_FPU   = 3'd1,
      RID_NSLK  = 3'd2,
      RID_SLK   = 3'd3,
      RID_SAFE  = 3'd4,
      RID_ERASE = 3'd5,
      RID_CCTL  = 3'd6,
      RID_CCODE = 3'd7
   } reg_id_e;

   localparam int NREG   = 8;
   localparam int IDX_W  = 3;
   localparam int SCFG_W = 4;

   // guard-bit positions inside the security-configuration register
   localparam int SG_SYS  = 0;
   localparam int SG_SAFE = 1;
   localparam int SG_FPU  = 3;

   localparam logic [SCFG_W-1:0] SCFG_MASK = 4'b1011;

   // decision for one access
   typedef struct packed {
      logic rd_ok;
      logic wr_ok;
      logic report;
   } verdict_t;

endpackage

// File: rtl/regsec_policy.sv
module regsec_policy
   import regsec_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              sec_en_i,
   input  logic              valid_i,
   input  logic              write_i,
   input  logic              secure_i,
   input  logic              priv_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [2:0]        guard_i,   // {fpu, safety, system}
   output verdict_t          verdict_o
);

   logic    mapped;
   reg_id_e id;
   logic    ns_acc;
   logic    guard_hit;
   logic    sec_blk;
   logic    sec_rep;
   logic    priv_blk;

   // indices above the bank read zero and report nothing
   if (ADDR_W > IDX_W) begin : g_wide
      assign mapped = ~|addr_i[ADDR_W-1:IDX_W];
   end else begin : g_exact
      assign mapped = 1'b1;
   end

   assign id     = reg_id_e'(addr_i[IDX_W-1:0]);
   assign ns_acc = sec_en_i & ~secure_i;

   always_comb begin
      case (id)
         RID_FPU:                        guard_hit = guard_i[2];
         RID_SAFE:                       guard_hit = guard_i[1];
         RID_ERASE, RID_CCTL, RID_CCODE: guard_hit = guard_i[0];
         default:                        guard_hit = 1'b0;
      endcase
   end

   always_comb begin
      sec_blk = 1'b0;
      sec_rep = 1'b0;
      case (id)
         RID_SCFG: begin
            sec_blk = ~sec_en_i | (write_i & ns_acc);
            sec_rep = write_i & ns_acc;
         end
         RID_SLK: begin
            sec_blk = ~sec_en_i | ns_acc;
            sec_rep = ns_acc;
         end
         RID_NSLK: begin
            sec_blk = 1'b0;
            sec_rep = 1'b0;
         end
         default: begin
            sec_blk = ns_acc & guard_hit;
            sec_rep = ns_acc & guard_hit;
         end
      endcase
   end

   always_comb begin
      priv_blk = ~priv_i & ((id == RID_FPU) | (id == RID_NSLK) | (id == RID_SLK));
   end

   always_comb begin
      verdict_o.rd_ok  = valid_i & mapped & ~write_i & ~sec_blk & ~priv_blk;
      verdict_o.wr_ok  = valid_i & mapped &  write_i & ~sec_blk & ~priv_blk;
      verdict_o.report = valid_i & mapped & sec_rep;
   end

endmodule

// File: rtl/regsec_field.sv
module regsec_field #(
   parameter int         W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= RST;
      end else if (we_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/regsec_filter.sv
module regsec_filter
   import regsec_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 32,
   parameter int FPU_W   = 6,
   parameter int NSLK_W  = 2,
   parameter int SLK_W   = 3,
   parameter int SAFE_W  = 4,
   parameter int ERASE_W = 2,
   parameter int CCTL_W  = 2,
   parameter int CCODE_W = 8,
   parameter logic [FPU_W-1:0]   FPU_RST   = 'h1F,
   parameter logic [CCODE_W-1:0] CCODE_RST = 'h78
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_en_i,
   input  logic               acc_valid_i,
   input  logic               acc_write_i,
   input  logic [ADDR_W-1:0]  acc_addr_i,
   input  logic [DATA_W-1:0]  acc_wdata_i,
   input  logic               acc_secure_i,
   input  logic               acc_priv_i,
   output logic [DATA_W-1:0]  acc_rdata_o,
   output logic               illegal_evt_o,
   output logic [3:0]         sec_cfg_o,
   output logic [FPU_W-1:0]   fpu_ie_o,
   output logic [NSLK_W-1:0]  ns_lock_o,
   output logic [SLK_W-1:0]   s_lock_o,
   output logic [SAFE_W-1:0]  safe_lock_o,
   output logic [ERASE_W-1:0] erase_o,
   output logic [CCTL_W-1:0]  comp_ctl_o,
   output logic [CCODE_W-1:0] comp_code_o
);

   // ---------------- elaboration checks ----------------
   localparam int MAX_W0 = (FPU_W  > NSLK_W)  ? FPU_W  : NSLK_W;
   localparam int MAX_W1 = (SLK_W  > SAFE_W)  ? SLK_W  : SAFE_W;
   localparam int MAX_W2 = (ERASE_W > CCTL_W) ? ERASE_W : CCTL_W;
   localparam int MAX_W3 = (CCODE_W > SCFG_W) ? CCODE_W : SCFG_W;
   localparam int MAX_WA = (MAX_W0 > MAX_W1) ? MAX_W0 : MAX_W1;
   localparam int MAX_WB = (MAX_W2 > MAX_W3) ? MAX_W2 : MAX_W3;
   localparam int MAX_W  = (MAX_WA > MAX_WB) ? MAX_WA : MAX_WB;

   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W must cover the eight-register bank");
   end
   if (DATA_W < MAX_W) begin : g_bad_data
      $error("DATA_W narrower than the widest register");
   end
   if (FPU_W < 6) begin : g_bad_fpu
      $error("FPU mask needs at least six enables");
   end

   // ---------------- per-register geometry ----------------
   function automatic int reg_w(input int idx);
      case (idx)
         0:       return SCFG_W;
         1:       return FPU_W;
         2:       return NSLK_W;
         3:       return SLK_W;
         4:       return SAFE_W;
         5:       return ERASE_W;
         6:       return CCTL_W;
         default: return CCODE_W;
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] reg_rst(input int idx);
      case (idx)
         1:       return DATA_W'(FPU_RST);
         7:       return DATA_W'(CCODE_RST);
         default: return '0;
      endcase
   endfunction

   // ---------------- access decision ----------------
   verdict_t                  verd;
   logic [DATA_W-1:0]         q_all [NREG];
   logic [NREG-1:0]           wr_hit;
   logic [SCFG_W-1:0]         scfg_q;
   logic [SCFG_W-1:0]         scfg_wd;
   logic [IDX_W-1:0]          idx;

   assign idx    = acc_addr_i[IDX_W-1:0];
   assign scfg_q = q_all[RID_SCFG][SCFG_W-1:0];

   regsec_policy #(
      .ADDR_W (ADDR_W)
   ) u_policy (
      .sec_en_i  (sec_en_i),
      .valid_i   (acc_valid_i),
      .write_i   (acc_write_i),
      .secure_i  (acc_secure_i),
      .priv_i    (acc_priv_i),
      .addr_i    (acc_addr_i),
      .guard_i   ({scfg_q[SG_FPU], scfg_q[SG_SAFE], scfg_q[SG_SYS]}),
      .verdict_o (verd)
   );

   // unprivileged writers cannot move the FPU guard bit
   always_comb begin
      scfg_wd = acc_wdata_i[SCFG_W-1:0] & SCFG_MASK;
      if (!acc_priv_i) begin
         scfg_wd[SG_FPU] = scfg_q[SG_FPU];
      end
   end

   always_comb begin
      wr_hit = '0;
      if (verd.wr_ok) begin
         wr_hit[idx] = 1'b1;
      end
   end

   // ---------------- register bank ----------------
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam int              W     = reg_w(i);
      localparam logic [DATA_W-1:0] RFULL = reg_rst(i);
      logic [W-1:0] d;
      logic [W-1:0] q;

      if (i == int'(RID_SCFG)) begin : g_cfg
         assign d = W'(scfg_wd);
      end else begin : g_plain
         assign d = W'(acc_wdata_i);
      end

      regsec_field #(
         .W   (W),
         .RST (RFULL[W-1:0])
      ) u_field (
         .clk   (clk),
         .rst_n (rst_n),
         .we_i  (wr_hit[i]),
         .d_i   (d),
         .q_o   (q)
      );

      assign q_all[i] = DATA_W'(q);
   end

   // ---------------- outputs ----------------
   assign acc_rdata_o   = verd.rd_ok ? q_all[idx] : '0;
   assign illegal_evt_o = verd.report;

   assign sec_cfg_o   = scfg_q;
   assign fpu_ie_o    = q_all[RID_FPU][FPU_W-1:0];
   assign ns_lock_o   = q_all[RID_NSLK][NSLK_W-1:0];
   assign s_lock_o    = q_all[RID_SLK][SLK_W-1:0];
   assign safe_lock_o = q_all[RID_SAFE][SAFE_W-1:0];
   assign erase_o     = q_all[RID_ERASE][ERASE_W-1:0];
   assign comp_ctl_o  = q_all[RID_CCTL][CCTL_W-1:0];
   assign comp_code_o = q_all[RID_CCODE][CCODE_W-1:0];

endmodule

// File: rtl/regsec_checker.sv
module regsec_checker #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int FPU_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_en_i,
   input logic              acc_valid_i,
   input logic              acc_write_i,
   input logic [ADDR_W-1:0] acc_addr_i,
   input logic              acc_secure_i,
   input logic              acc_priv_i,
   input logic [DATA_W-1:0] acc_rdata_o,
   input logic              illegal_evt_o,
   input logic [3:0]        sec_cfg_o,
   input logic [FPU_W-1:0]  fpu_ie_o
);

   logic a_cfg, a_fpu, a_nsl, a_sl, a_sys;

   assign a_cfg = (acc_addr_i == ADDR_W'(0));
   assign a_fpu = (acc_addr_i == ADDR_W'(1));
   assign a_nsl = (acc_addr_i == ADDR_W'(2));
   assign a_sl  = (acc_addr_i == ADDR_W'(3));
   assign a_sys = (acc_addr_i == ADDR_W'(5)) || (acc_addr_i == ADDR_W'(6)) ||
                  (acc_addr_i == ADDR_W'(7));

   // R9
   evt_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_evt_o |-> (acc_valid_i && sec_en_i && !acc_secure_i));

   // R2
   off_raz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && !sec_en_i && (a_cfg || a_sl)) |-> (acc_rdata_o == '0 && !illegal_evt_o));

   // R4
   cfg_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_cfg_o[2] == 1'b0);

   // R3
   cfg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_cfg_o != $past(sec_cfg_o)) |->
         $past(acc_valid_i && acc_write_i && acc_secure_i && sec_en_i && a_cfg));

   // R7
   priv_raz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && !acc_priv_i && (a_fpu || a_nsl || a_sl)) |-> (acc_rdata_o == '0));

   // R7
   fpu_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fpu_ie_o != $past(fpu_ie_o)) |->
         $past(acc_valid_i && acc_write_i && acc_priv_i && a_fpu));

   // R5
   guard_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && sec_en_i && !acc_secure_i && sec_cfg_o[0] && a_sys) |->
         (acc_rdata_o == '0 && illegal_evt_o));

   // R8
   both_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && sec_en_i && !acc_secure_i && !acc_priv_i && a_sl) |->
         (acc_rdata_o == '0 && illegal_evt_o));

endmodule

bind regsec_filter regsec_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .FPU_W  (FPU_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sec_en_i      (sec_en_i),
   .acc_valid_i   (acc_valid_i),
   .acc_write_i   (acc_write_i),
   .acc_addr_i    (acc_addr_i),
   .acc_secure_i  (acc_secure_i),
   .acc_priv_i    (acc_priv_i),
   .acc_rdata_o   (acc_rdata_o),
   .illegal_evt_o (illegal_evt_o),
   .sec_cfg_o     (sec_cfg_o),
   .fpu_ie_o      (fpu_ie_o)
);

// File: tb/regsec_filter_bench.sv
module regsec_filter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_en_i = 1'b1;
   logic        acc_valid_i = 1'b0;
   logic        acc_write_i = 1'b0;
   logic [2:0]  acc_addr_i = '0;
   logic [31:0] acc_wdata_i = '0;
   logic        acc_secure_i = 1'b1;
   logic        acc_priv_i = 1'b1;
   logic [31:0] acc_rdata_o;
   logic        illegal_evt_o;
   logic [3:0]  sec_cfg_o;
   logic [5:0]  fpu_ie_o;
   logic [1:0]  ns_lock_o;
   logic [2:0]  s_lock_o;
   logic [3:0]  safe_lock_o;
   logic [1:0]  erase_o;
   logic [1:0]  comp_ctl_o;
   logic [7:0]  comp_code_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   regsec_filter u_regsec_filter (
      .clk           (clk),
      .rst_n         (rst_n),
      .sec_en_i      (sec_en_i),
      .acc_valid_i   (acc_valid_i),
      .acc_write_i   (acc_write_i),
      .acc_addr_i    (acc_addr_i),
      .acc_wdata_i   (acc_wdata_i),
      .acc_secure_i  (acc_secure_i),
      .acc_priv_i    (acc_priv_i),
      .acc_rdata_o   (acc_rdata_o),
      .illegal_evt_o (illegal_evt_o),
      .sec_cfg_o     (sec_cfg_o),
      .fpu_ie_o      (fpu_ie_o),
      .ns_lock_o     (ns_lock_o),
      .s_lock_o      (s_lock_o),
      .safe_lock_o   (safe_lock_o),
      .erase_o       (erase_o),
      .comp_ctl_o    (comp_ctl_o),
      .comp_code_o   (comp_code_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one bus access; samples read data and the event in the access cycle
   task automatic access(input logic [2:0] a, input logic wr, input logic [31:0] wd,
                         input logic sec, input logic prv,
                         output logic [31:0] rd, output logic ev);
      @(negedge clk);
      acc_valid_i  = 1'b1;
      acc_write_i  = wr;
      acc_addr_i   = a;
      acc_wdata_i  = wd;
      acc_secure_i = sec;
      acc_priv_i   = prv;
      #2;
      rd = acc_rdata_o;
      ev = illegal_evt_o;
      @(negedge clk);
      acc_valid_i = 1'b0;
   endtask

   task automatic wr_chk(input string req, input logic [2:0] a, input logic [31:0] wd,
                         input logic sec, input logic prv, input logic exp_ev);
      logic [31:0] rd;
      logic ev;
      access(a, 1'b1, wd, sec, prv, rd, ev);
      chk(req, 32'(ev), 32'(exp_ev));
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic sec,
                         input logic prv, input logic [31:0] exp_d, input logic exp_ev);
      logic [31:0] rd;
      logic ev;
      access(a, 1'b0, '0, sec, prv, rd, ev);
      chk(req, rd, exp_d);
      chk(req, 32'(ev), 32'(exp_ev));
   endtask

   task automatic set_cfg(input logic [31:0] v);
      logic [31:0] rd;
      logic ev;
      access(3'd0, 1'b1, v, 1'b1, 1'b1, rd, ev);
   endtask

   task automatic t_reset;
      rd_chk("R1 cfg",   3'd0, 1, 1, 32'h0,  0);
      rd_chk("R1 fpu",   3'd1, 1, 1, 32'h1F, 0);
      rd_chk("R1 nslk",  3'd2, 1, 1, 32'h0,  0);
      rd_chk("R1 slk",   3'd3, 1, 1, 32'h0,  0);
      rd_chk("R1 safe",  3'd4, 1, 1, 32'h0,  0);
      rd_chk("R1 erase", 3'd5, 1, 1, 32'h0,  0);
      rd_chk("R1 cctl",  3'd6, 1, 1, 32'h0,  0);
      rd_chk("R1 ccode", 3'd7, 1, 1, 32'h78, 0);
      chk("R1 fpu port bit5 clear", 32'(fpu_ie_o), 32'h1F);
   endtask

   task automatic t_disabled;
      sec_en_i = 1'b0;
      wr_chk("R2 cfg write no event", 3'd0, 32'hB, 1, 1, 0);
      rd_chk("R2 cfg raz", 3'd0, 1, 1, 32'h0, 0);
      wr_chk("R2 slk write no event", 3'd3, 32'h7, 1, 1, 0);
      rd_chk("R2 slk raz", 3'd3, 1, 1, 32'h0, 0);
      sec_en_i = 1'b1;
      rd_chk("R2 cfg write ignored", 3'd0, 1, 1, 32'h0, 0);
      rd_chk("R2 slk write ignored", 3'd3, 1, 1, 32'h0, 0);
   endtask

   task automatic t_layout;
      set_cfg(32'hFFFF_FFFF);
      rd_chk("R4 only bits 0,1,3", 3'd0, 1, 1, 32'hB, 0);
      chk("R4 port", 32'(sec_cfg_o), 32'hB);
      set_cfg(32'h0);
   endtask

   task automatic t_cfg_ns;
      set_cfg(32'h1);
      rd_chk("R3 ns unpriv read", 3'd0, 0, 0, 32'h1, 0);
      wr_chk("R3 ns write event", 3'd0, 32'hB, 0, 1, 1);
      rd_chk("R3 ns write ignored", 3'd0, 1, 1, 32'h1, 0);
   endtask

   task automatic t_guard;
      // system guard set (cfg = 1)
      wr_chk("R5 sys guard ns write event", 3'd7, 32'h55, 0, 1, 1);
      rd_chk("R5 sys guard ns read", 3'd7, 0, 1, 32'h0, 1);
      rd_chk("R5 sys guard write ignored", 3'd7, 1, 1, 32'h78, 0);
      wr_chk("R5 safe open ns write", 3'd4, 32'hF, 0, 0, 0);
      rd_chk("R5 safe open ns read", 3'd4, 0, 0, 32'hF, 0);
      set_cfg(32'h2);
      rd_chk("R5 safe guard ns read", 3'd4, 0, 0, 32'h0, 1);
      wr_chk("R5 safe guard ns write", 3'd4, 32'h0, 0, 0, 1);
      rd_chk("R5 safe guard kept", 3'd4, 1, 0, 32'hF, 0);
      set_cfg(32'h0);
      wr_chk("R5 sys open ns write", 3'd7, 32'h55, 0, 0, 0);
      rd_chk("R5 sys open ns read", 3'd7, 0, 0, 32'h55, 0);
      set_cfg(32'h8);
      wr_chk("R5 fpu guard ns write", 3'd1, 32'h3, 0, 1, 1);
      rd_chk("R5 fpu guard kept", 3'd1, 1, 1, 32'h1F, 0);
      set_cfg(32'h0);
      rd_chk("R5 fpu open ns priv read", 3'd1, 0, 1, 32'h1F, 0);
   endtask

   task automatic t_priv;
      wr_chk("R7 fpu unpriv write silent", 3'd1, 32'h3, 1, 0, 0);
      rd_chk("R7 fpu unpriv write ignored", 3'd1, 1, 1, 32'h1F, 0);
      rd_chk("R7 fpu unpriv raz", 3'd1, 1, 0, 32'h0, 0);
      wr_chk("R7 nslk unpriv write silent", 3'd2, 32'h3, 0, 0, 0);
      rd_chk("R7 nslk unpriv write ignored", 3'd2, 1, 1, 32'h0, 0);
      wr_chk("R7 nslk priv write", 3'd2, 32'h3, 0, 1, 0);
      rd_chk("R7 nslk priv read", 3'd2, 0, 1, 32'h3, 0);
      wr_chk("R7 slk unpriv secure silent", 3'd3, 32'h7, 1, 0, 0);
      rd_chk("R7 slk unpriv ignored", 3'd3, 1, 1, 32'h0, 0);
   endtask

   task automatic t_bit3;
      wr_chk("R6 unpriv cfg write", 3'd0, 32'hB, 1, 0, 0);
      rd_chk("R6 bit3 held, others set", 3'd0, 1, 1, 32'h3, 0);
      wr_chk("R6 priv cfg write", 3'd0, 32'hB, 1, 1, 0);
      rd_chk("R6 priv sets bit3", 3'd0, 1, 1, 32'hB, 0);
      wr_chk("R6 unpriv clear", 3'd0, 32'h0, 1, 0, 0);
      rd_chk("R6 bit3 survives unpriv clear", 3'd0, 1, 0, 32'h8, 0);
      set_cfg(32'h0);
   endtask

   task automatic t_both;
      set_cfg(32'h8);
      rd_chk("R8 fpu ns unpriv", 3'd1, 0, 0, 32'h0, 1);
      wr_chk("R8 slk ns unpriv write", 3'd3, 32'h7, 0, 0, 1);
      rd_chk("R8 slk ns unpriv read", 3'd3, 0, 0, 32'h0, 1);
      set_cfg(32'h0);
   endtask

   task automatic t_slk;
      wr_chk("R10 slk secure write", 3'd3, 32'h5, 1, 1, 0);
      rd_chk("R10 slk secure read", 3'd3, 1, 1, 32'h5, 0);
      rd_chk("R10 slk ns read", 3'd3, 0, 1, 32'h0, 1);
      wr_chk("R10 slk ns write", 3'd3, 32'h0, 0, 1, 1);
      rd_chk("R10 slk ns write ignored", 3'd3, 1, 1, 32'h5, 0);
      chk("R10 slk port", 32'(s_lock_o), 32'h5);
   endtask

   task automatic t_timing;
      // idle cycle following a reporting access, nonsecure attributes still driven
      wr_chk("R9 reporting access", 3'd3, 32'h0, 0, 1, 1);
      #1;
      chk("R9 idle no pulse", 32'(illegal_evt_o), 32'h0);
      // write data lands only after the edge
      @(negedge clk);
      acc_valid_i  = 1'b1;
      acc_write_i  = 1'b1;
      acc_addr_i   = 3'd1;
      acc_wdata_i  = 32'hFF;
      acc_secure_i = 1'b1;
      acc_priv_i   = 1'b1;
      #2;
      chk("R11 before edge", 32'(fpu_ie_o), 32'h1F);
      @(posedge clk);
      #1;
      chk("R11 after edge, width 6", 32'(fpu_ie_o), 32'h3F);
      @(negedge clk);
      acc_valid_i = 1'b0;
      rd_chk("R11 same-cycle read", 3'd1, 1, 1, 32'h3F, 0);
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_disabled();
      t_layout();
      t_cfg_ns();
      t_guard();
      t_priv();
      t_bit3();
      t_both();
      t_slk();
      t_timing();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule